// File: doc/BRIEF.md
# Password Attempts Limiter

This block keeps track of wrong password presentations and failed authentication attempts for a secure serial memory. It holds five attempt counters, four for passwords and one for the authentication exchange. It raises a verified flag for each credential that was presented correctly. Once a credential has reached its limit of consecutive wrong presentations, the block raises a locked flag for it. Another unit compares the presented value and reports the result. This block only receives a verify request with a credential index and a match or mismatch bit.

Each counter is an 8-bit mask that starts at all ones. Every failure clears one more bit, starting at bit 0, and a successful presentation refills the mask. Two active-low configuration inputs choose the limit and the authentication mode. The first one raises the limit from four trials to eight. The second one stops the authentication counter so that authentication can be tried any number of times. A high level on the card reset input withdraws every granted access and leaves the counters alone. The asynchronous `rst_n` input stands in for power-up of the nonvolatile counter storage. All counter values go out on one bus, because the authentication counter feeds the next authentication exchange.

Top module: `pw_attempt_limiter`

## Requirements
- R1: After `rst_n` is asserted, every counter reads 8'hFF and all `verified`, `locked` and `vfy_done` bits are 0.
- R2: A mismatch on a credential that is neither locked nor unlimited shifts its counter left by one, so bit 0 is cleared first. The counter is always a run of ones above a run of zeros.
- R3: With `cfg_ext_trials_n`=1, a credential is locked after exactly four consecutive mismatches and not before.
- R4: With `cfg_ext_trials_n`=0, a credential is locked after exactly eight consecutive mismatches, for passwords and for authentication alike.
- R5: A match on a credential that is not locked sets its `verified` bit and refills its counter to 8'hFF, which restarts the count of consecutive failures. A later mismatch decrements the counter but leaves `verified` set.
- R6: A request for a locked credential is rejected even when it matches. Its counter and `verified` bit do not change and its `locked` bit stays 1.
- R7: With `cfg_unlim_auth_n`=0, authentication (index 4) mismatches leave its counter unchanged and it is never locked. The password counters still apply their limit.
- R8: While `card_rst` is 1, every `verified` bit clears on the next edge and all counters keep their values. A request made in the same cycle has no effect and produces no `vfy_done`.
- R9: `vfy_done` is 1 in the cycle after every request accepted while `card_rst` is 0, and 0 otherwise. Indices 5 to 7 produce `vfy_done` but change no state.
- R10: `attempt_ctr` shows counter i in bits [8i+7:8i]. Indices 0 to 3 are the passwords and index 4 is authentication, in bits [39:32].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, power-up of counter storage |
| card_rst | input | 1 | Card reset; drops all granted access |
| vfy_req | input | 1 | Verify request strobe |
| vfy_idx | input | 3 | Credential index: 0-3 password, 4 authentication |
| vfy_match | input | 1 | 1 when the presented value matched |
| cfg_ext_trials_n | input | 1 | Active low: eight-trial limit |
| cfg_unlim_auth_n | input | 1 | Active low: unlimited authentication |
| verified | output | 5 | Per-credential access granted |
| locked | output | 5 | Per-credential limit reached |
| vfy_done | output | 1 | Pulse one cycle after an accepted request |
| attempt_ctr | output | 40 | All five counter masks |

## Verification
Every result is registered once. The counters, `verified` and `vfy_done` therefore change on the clock edge that samples the request and are read one cycle after the request is driven. `locked` is derived from the counter and the configuration without a further register, so it is due in that same cycle. It also follows a configuration change with no delay. The bench drives inputs on the falling edge, releases the request on the next falling edge and compares the outputs there. It sweeps every credential, both trial limits and both authentication modes for every failure count from zero to beyond the limit.

// File: rtl/pal_pkg.sv
package pal_pkg;
  // outcome of one request as seen by a single credential slot
  typedef enum logic [1:0] {
    OUT_IDLE   = 2'd0,
    OUT_GRANT  = 2'd1,
    OUT_FAIL   = 2'd2,
    OUT_REJECT = 2'd3
  } pal_outcome_e;
endpackage

// File: rtl/pal_req_decode.sv
module pal_req_decode #(
  parameter int NUM_CRED = 5,
  parameter int IDX_W    = 3
) (
  input  logic                card_rst,
  input  logic                vfy_req,
  input  logic [IDX_W-1:0]    vfy_idx,
  output logic                accept,
  output logic [NUM_CRED-1:0] sel
);
  assign accept = vfy_req && !card_rst;

  for (genvar g = 0; g < NUM_CRED; g++) begin : g_sel
    assign sel[g] = accept && (vfy_idx == IDX_W'(g));
  end
endmodule

// File: rtl/pal_slot.sv
module pal_slot
  import pal_pkg::*;
#(
  parameter int CTR_W       = 8,
  parameter int BASE_TRIALS = 4,
  parameter int EXT_TRIALS  = 8,
  parameter bit CAN_UNLIMIT = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             card_rst,
  input  logic             sel,
  input  logic             match,
  input  logic             ext_trials_n,
  input  logic             unlim_n,
  output logic [CTR_W-1:0] mask_q,
  output logic             verified_q,
  output logic             locked
);
  localparam int LB_W = (CTR_W > 1) ? $clog2(CTR_W) : 1;

  logic [LB_W-1:0]  lim_bit;
  logic             unlimited;
  pal_outcome_e     outcome;
  logic [CTR_W-1:0] mask_nxt;
  logic             mask_en;
  logic             ver_nxt;

  // the bit that clears on the limiting failure
  assign lim_bit   = ext_trials_n ? LB_W'(BASE_TRIALS - 1) : LB_W'(EXT_TRIALS - 1);
  assign unlimited = CAN_UNLIMIT && !unlim_n;
  assign locked    = !unlimited && !mask_q[lim_bit];

  always_comb begin
    if (!sel)        outcome = OUT_IDLE;
    else if (locked) outcome = OUT_REJECT;
    else if (match)  outcome = OUT_GRANT;
    else             outcome = OUT_FAIL;
  end

  always_comb begin
    mask_en  = 1'b0;
    mask_nxt = mask_q;
    case (outcome)
      OUT_GRANT: begin
        mask_en  = 1'b1;
        mask_nxt = '1;
      end
      OUT_FAIL: begin
        mask_en  = !unlimited;
        mask_nxt = {mask_q[CTR_W-2:0], 1'b0};
      end
      default: begin
        mask_en  = 1'b0;
        mask_nxt = mask_q;
      end
    endcase
  end

  always_comb begin
    if (card_rst)                  ver_nxt = 1'b0;
    else if (outcome == OUT_GRANT) ver_nxt = 1'b1;
    else                           ver_nxt = verified_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '1;
    else if (mask_en) mask_q <= mask_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) verified_q <= 1'b0;
    else        verified_q <= ver_nxt;
  end

  // R2
  mask_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (((~mask_q) & ((~mask_q) + 1'b1)) == '0));

  // R2
  fail_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && !match && !locked && !unlimited) |=> (mask_q == {$past(mask_q[CTR_W-2:0]), 1'b0}));

  // R6
  locked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && locked) |=> $stable(mask_q));

  // R7
  unlim_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && unlimited && !match) |=> $stable(mask_q));

  // R8
  grant_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    card_rst |=> !verified_q);

  // R5
  grant_refill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && match && !locked) |=> (verified_q && (mask_q == '1)));
endmodule

// File: rtl/pw_attempt_limiter.sv
module pw_attempt_limiter #(
  parameter int CTR_W       = 8,
  parameter int NUM_PW      = 4,
  parameter int BASE_TRIALS = 4,
  parameter int EXT_TRIALS  = 8,
  parameter int IDX_W       = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          card_rst,
  input  logic                          vfy_req,
  input  logic [IDX_W-1:0]              vfy_idx,
  input  logic                          vfy_match,
  input  logic                          cfg_ext_trials_n,
  input  logic                          cfg_unlim_auth_n,
  output logic [NUM_PW:0]               verified,
  output logic [NUM_PW:0]               locked,
  output logic                          vfy_done,
  output logic [(NUM_PW+1)*CTR_W-1:0]   attempt_ctr
);
  localparam int NUM_CRED = NUM_PW + 1;
  localparam int AUTH_IDX = NUM_PW;

  logic                accept;
  logic [NUM_CRED-1:0] sel;
  logic                done_nxt;
  logic                done_q;

  pal_req_decode #(
    .NUM_CRED (NUM_CRED),
    .IDX_W    (IDX_W)
  ) u_dec (
    .card_rst (card_rst),
    .vfy_req  (vfy_req),
    .vfy_idx  (vfy_idx),
    .accept   (accept),
    .sel      (sel)
  );

  for (genvar g = 0; g < NUM_CRED; g++) begin : g_slot
    pal_slot #(
      .CTR_W       (CTR_W),
      .BASE_TRIALS (BASE_TRIALS),
      .EXT_TRIALS  (EXT_TRIALS),
      .CAN_UNLIMIT (g == AUTH_IDX)
    ) u_slot (
      .clk          (clk),
      .rst_n        (rst_n),
      .card_rst     (card_rst),
      .sel          (sel[g]),
      .match        (vfy_match),
      .ext_trials_n (cfg_ext_trials_n),
      .unlim_n      (cfg_unlim_auth_n),
      .mask_q       (attempt_ctr[g*CTR_W +: CTR_W]),
      .verified_q   (verified[g]),
      .locked       (locked[g])
    );
  end

  assign done_nxt = accept;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= done_nxt;
  end

  assign vfy_done = done_q;

  // R9
  done_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vfy_req && !card_rst) |=> vfy_done);

  // R9
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(vfy_req && !card_rst) |=> !vfy_done);

  // R7
  auth_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_unlim_auth_n |-> !locked[AUTH_IDX]);

  // R8
  card_rst_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    card_rst |=> $stable(attempt_ctr));
endmodule

// File: tb/pw_attempt_limiter_test.sv
`timescale 1ns/1ps
module pw_attempt_limiter_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        card_rst = 1'b0;
  logic        vfy_req = 1'b0;
  logic [2:0]  vfy_idx = '0;
  logic        vfy_match = 1'b0;
  logic        cfg_ext_trials_n = 1'b1;
  logic        cfg_unlim_auth_n = 1'b1;
  logic [4:0]  verified;
  logic [4:0]  locked;
  logic        vfy_done;
  logic [39:0] attempt_ctr;

  int checks = 0;
  int errors = 0;
  bit ended = 1'b0;

  always #4 clk = ~clk;

  pw_attempt_limiter uut (
    .clk(clk), .rst_n(rst_n), .card_rst(card_rst), .vfy_req(vfy_req),
    .vfy_idx(vfy_idx), .vfy_match(vfy_match),
    .cfg_ext_trials_n(cfg_ext_trials_n), .cfg_unlim_auth_n(cfg_unlim_auth_n),
    .verified(verified), .locked(locked), .vfy_done(vfy_done),
    .attempt_ctr(attempt_ctr)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // drive on falling edge, result read on the next falling edge
  task automatic do_req(input logic [2:0] idx, input logic m);
    vfy_idx = idx;
    vfy_match = m;
    vfy_req = 1'b1;
    @(negedge clk);
    vfy_req = 1'b0;
  endtask

  initial begin
    #1500000;
    if (!ended) begin
      ended = 1'b1;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 ctr", {24'h0, attempt_ctr}, {24'h0, {5{8'hFF}}});
    chk("R1 verified", {59'h0, verified}, 64'h0);
    chk("R1 locked", {59'h0, locked}, 64'h0);
    chk("R1 done", {63'h0, vfy_done}, 64'h0);

    // sweep: limit mode x auth mode x credential x failure count
    for (int e = 0; e < 2; e++) begin
      for (int u = 0; u < 2; u++) begin
        for (int c = 0; c < 5; c++) begin
          for (int k = 0; k < 10; k++) begin
            int lim;
            int eff;
            bit unl;
            bit lk;
            logic [39:0] exp_ctr;
            cfg_ext_trials_n = e[0];
            cfg_unlim_auth_n = u[0];
            do_reset();
            lim = (e == 1) ? 4 : 8;
            unl = (c == 4) && (u == 0);
            eff = unl ? 0 : ((k < lim) ? k : lim);
            lk  = !unl && (k >= lim);
            for (int f = 0; f < k; f++) begin
              do_req(3'(c), 1'b0);
              chk("R9 done after fail", {63'h0, vfy_done}, 64'h1);
            end
            exp_ctr = {5{8'hFF}};
            exp_ctr[c*8 +: 8] = 8'hFF << eff;
            // R2 R3 R4 R7 R10 counter shape and position
            chk($sformatf("R2 ctr e%0d u%0d c%0d k%0d", e, u, c, k), {24'h0, attempt_ctr}, {24'h0, exp_ctr});
            chk($sformatf("R3 R4 R7 locked e%0d u%0d c%0d k%0d", e, u, c, k),
                {59'h0, locked}, {59'h0, (5'(lk) << c)});
            do_req(3'(c), 1'b1);
            if (!lk) exp_ctr[c*8 +: 8] = 8'hFF;
            // R5 grant or R6 reject
            chk($sformatf("R5 R6 verified e%0d u%0d c%0d k%0d", e, u, c, k),
                {59'h0, verified}, {59'h0, (5'(!lk) << c)});
            chk($sformatf("R5 R6 ctr after match c%0d k%0d", c, k), {24'h0, attempt_ctr}, {24'h0, exp_ctr});
          end
        end
      end
    end

    // R5 refill restarts consecutive count; verified survives a later mismatch
    cfg_ext_trials_n = 1'b1;
    cfg_unlim_auth_n = 1'b1;
    do_reset();
    for (int f = 0; f < 3; f++) do_req(3'd1, 1'b0);
    do_req(3'd1, 1'b1);
    for (int f = 0; f < 3; f++) do_req(3'd1, 1'b0);
    chk("R5 count restarted", {59'h0, locked}, 64'h0);
    chk("R5 ctr after restart", {56'h0, attempt_ctr[15:8]}, 64'hF8);
    chk("R5 verified kept", {59'h0, verified}, 64'h2);

    // R8 card reset drops grants, keeps counters
    do_reset();
    do_req(3'd0, 1'b1);
    do_req(3'd4, 1'b1);
    chk("R8 grants before", {59'h0, verified}, 64'h11);
    do_req(3'd4, 1'b0);
    do_req(3'd4, 1'b0);
    chk("R8 auth ctr", {56'h0, attempt_ctr[39:32]}, 64'hFC);
    card_rst = 1'b1;
    do_req(3'd2, 1'b1);
    chk("R8 no done under card reset", {63'h0, vfy_done}, 64'h0);
    card_rst = 1'b0;
    chk("R8 grants dropped", {59'h0, verified}, 64'h0);
    chk("R8 ctr kept", {24'h0, attempt_ctr}, {24'h0, 8'hFC, {4{8'hFF}}});

    // R9 indices without a credential
    for (int i = 5; i < 8; i++) begin
      do_req(3'(i), 1'b1);
      chk("R9 done spare index", {63'h0, vfy_done}, 64'h1);
      chk("R9 spare index no grant", {59'h0, verified}, 64'h0);
      chk("R9 spare index ctr", {24'h0, attempt_ctr}, {24'h0, 8'hFC, {4{8'hFF}}});
    end
    @(negedge clk);
    chk("R9 done idle", {63'h0, vfy_done}, 64'h0);

    // R3 R4 locked follows limit config without delay
    do_reset();
    for (int f = 0; f < 5; f++) do_req(3'd3, 1'b0);
    cfg_ext_trials_n = 1'b0;
    #1;
    chk("R4 unlocked at eight", {59'h0, locked}, 64'h0);
    cfg_ext_trials_n = 1'b1;
    #1;
    chk("R3 locked at four", {59'h0, locked}, 64'h8);

    if (!ended) begin
      ended = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule